// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block is the part of an SDRAM controller that handles all refresh work. A free-running interval timer adds one owed refresh every `T_REFI` clock cycles. Whenever something is owed, the block raises a request to the controller's bus arbiter. When the arbiter grants the bus, the block takes the command pins and drains every owed refresh back to back, keeping the required `T_RC` gap after each one. Owed refreshes may wait behind normal traffic, but only up to `MAX_POSTPONE` of them. At that limit an urgency flag tells the arbiter that it must grant the bus.

The host can also ask for power-down by holding `pd_req_i` high. Once nothing is owed and the bus is granted, the block issues a refresh command and drops CKE in the same cycle. It keeps CKE low until the host withdraws the request and the minimum low time has passed. A withdrawal that comes too early is held until the exit is allowed. On exit the block raises CKE, drives NOPs for `T_RC` cycles, and then issues `CATCHUP_N` refreshes spaced `T_RC` apart, because the row that was refreshed last is unknown. After that it clears its owed count, restarts the interval timer and gives the bus back.

The block assumes that every bank is precharged whenever the bus is granted to it. `T_RC` and `T_RAS` must both be at least 2.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, and after each catch-up sequence, the first refresh is owed `T_REFI` clock edges later. Another is owed every `T_REFI` edges after that. `req_o` rises in the cycle after an obligation arises while the block is idle.
- R2: Command pins {cs_n, ras_n, cas_n, we_n} encode a refresh as 0,0,0,1 and a NOP as 0,1,1,1. Whenever `own_o` is low, the pins show NOP and `cke_o` is 1.
- R3: Owed refreshes are issued back to back, each exactly `T_RC` cycles after the one before, with only NOPs between them. The bus is released `T_RC` cycles after the last one.
- R4: The owed count saturates at `MAX_POSTPONE`, and `urgent_o` is high exactly while the count is at that limit. A drain issues exactly the owed count.
- R5: In idle, `req_o` is high when a refresh is owed or `pd_req_i` is high. With no grant the block issues nothing. `own_o` and the first command appear in the cycle after the edge that samples `gnt_i` high.
- R6: Owed refreshes come before self-refresh entry. Entry is issued `T_RC` cycles after the last owed refresh, without releasing the bus.
- R7: Self-refresh entry is a refresh command with `cke_o` falling in the same cycle. `cke_o` stays low for as long as `pd_req_i` stays high.
- R8: `cke_o` stays low for at least `T_RAS` cycles. A withdrawal of `pd_req_i` seen during entry or self-refresh is latched, and the exit happens even if the request is raised again. The exit happens in the first cycle in which it is allowed.
- R9: After `cke_o` rises, exactly `T_RC` NOP cycles pass before the next command.
- R10: After exit, `CATCHUP_N` refreshes are issued `T_RC` apart. The bus is released `T_RC` cycles after the last one, with the owed count cleared and the interval timer restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Host power-down request (level) |
| gnt_i | input | 1 | Bus grant from the arbiter |
| req_o | output | 1 | Bus request to the arbiter |
| urgent_o | output | 1 | Owed-refresh limit reached; the arbiter must grant |
| own_o | output | 1 | Block is driving the command pins |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
Each output is decoded from registered state, so a stimulus that is sampled at an edge shows its effect in the cycle after that edge. An owed refresh appears on `req_o` `T_REFI` edges after reset or after a catch-up release. A granted command appears one cycle after the grant is sampled, and the commands that follow sit at exact multiples of `T_RC`. A withdrawn power-down request raises `cke_o` one cycle later once `T_RAS` low cycles have passed. The bench drives inputs and samples outputs on falling edges. It records the falling-edge index of every refresh, every CKE change and every release, and compares each index with an exact arithmetic offset from the grant.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_RC_WAIT,
    ST_SR_ENTER,
    ST_SR,
    ST_SR_EXIT,
    ST_CU_REF,
    ST_CU_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_REF,
    OP_SR_ENTER
  } seq_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int T_REFI = 2600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int W = (T_REFI > 2) ? $clog2(T_REFI) : 1;
  localparam logic [W-1:0] LAST = W'(T_REFI - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R1: obligations never arrive on adjacent edges
  a_r1_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/sdram_ref_debt.sv
module sdram_ref_debt #(
  parameter int MAX_POSTPONE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic owed_o,
  output logic urgent_o
);
  localparam int W = $clog2(MAX_POSTPONE + 1);
  localparam logic [W-1:0] CAP = W'(MAX_POSTPONE);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CAP) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign owed_o   = (cnt_q != '0);
  assign urgent_o = (cnt_q == CAP);

  // R4: limit flag only drops through an issued refresh or a clear
  a_r4_urgent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o && !dec_i && !clear_i |=> urgent_o);

  // R4: issuing is only possible while something is owed
  a_r4_dec_owed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> owed_o);

endmodule

// File: rtl/sdram_ref_fsm.sv
module sdram_ref_fsm
  import sdram_ref_pkg::*;
#(
  parameter int T_RC      = 10,
  parameter int T_RAS     = 7,
  parameter int CATCHUP_N = 4096
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    owed_i,
  input  logic    pd_req_i,
  input  logic    gnt_i,
  output logic    req_o,
  output logic    own_o,
  output logic    cke_o,
  output logic    issue_o,
  output logic    clear_o,
  output seq_op_e op_o
);
  localparam int WMAX = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int CW   = $clog2(CATCHUP_N + 1);
  localparam int LW   = $clog2(T_RAS + 1);
  localparam logic [WW-1:0] RC_LAST   = WW'(T_RC - 2);
  localparam logic [WW-1:0] WAKE_LAST = WW'(T_RC - 1);
  localparam logic [WW-1:0] RES_MIN   = WW'(T_RAS - 2);
  localparam logic [WW-1:0] W_SAT     = WW'(WMAX);
  localparam logic [CW-1:0] CU_LAST   = CW'(CATCHUP_N);
  localparam logic [LW-1:0] LO_MIN    = LW'(T_RAS);

  seq_state_e    state_q, state_d;
  logic [WW-1:0] wcnt_q;
  logic [CW-1:0] cu_q;
  logic          exit_q;
  logic          rc_done, cu_done, in_sr, leave_ok;

  assign rc_done  = (wcnt_q == RC_LAST);
  assign cu_done  = (cu_q == CU_LAST);
  assign in_sr    = (state_q == ST_SR_ENTER) || (state_q == ST_SR);
  assign leave_ok = (exit_q || !pd_req_i) && (wcnt_q >= RES_MIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (gnt_i && owed_i)        state_d = ST_REF;
        else if (gnt_i && pd_req_i) state_d = ST_SR_ENTER;
      end
      ST_REF:     state_d = ST_RC_WAIT;
      ST_RC_WAIT: begin
        if (rc_done) begin
          if (owed_i)        state_d = ST_REF;
          else if (pd_req_i) state_d = ST_SR_ENTER;
          else               state_d = ST_IDLE;
        end
      end
      ST_SR_ENTER: state_d = ST_SR;
      ST_SR:       if (leave_ok) state_d = ST_SR_EXIT;
      ST_SR_EXIT:  if (wcnt_q == WAKE_LAST) state_d = ST_CU_REF;
      ST_CU_REF:   state_d = ST_CU_WAIT;
      ST_CU_WAIT: begin
        if (rc_done) state_d = cu_done ? ST_IDLE : ST_CU_REF;
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      cu_q    <= '0;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // per-state dwell counter, restarts on every transition
      if (state_d != state_q)  wcnt_q <= '0;
      else if (wcnt_q != W_SAT) wcnt_q <= wcnt_q + 1'b1;
      if (state_q == ST_SR_EXIT)    cu_q <= '0;
      else if (state_q == ST_CU_REF) cu_q <= cu_q + 1'b1;
      // queued exit: a withdrawal is remembered until the exit happens
      if (!in_sr)         exit_q <= 1'b0;
      else if (!pd_req_i) exit_q <= 1'b1;
    end
  end

  assign own_o   = (state_q != ST_IDLE);
  assign req_o   = own_o || owed_i || pd_req_i;
  assign cke_o   = !in_sr;
  assign issue_o = (state_q == ST_REF);
  assign clear_o = (state_q == ST_CU_WAIT) && rc_done && cu_done;

  always_comb begin
    unique case (state_q)
      ST_REF, ST_CU_REF: op_o = OP_REF;
      ST_SR_ENTER:       op_o = OP_SR_ENTER;
      default:           op_o = OP_NOP;
    endcase
  end

  // low-time checker for R8
  logic [LW-1:0] lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lo_run_q <= '0;
    else if (cke_o)           lo_run_q <= '0;
    else if (lo_run_q != LO_MIN) lo_run_q <= lo_run_q + 1'b1;
  end

  a_r8_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (lo_run_q == LO_MIN));

  a_r5_own_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_o) |-> $past(gnt_i));

  a_r7_low_while_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o && pd_req_i && !exit_q |=> !cke_o);

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_ref_pkg::*;
#(
  parameter int T_REFI       = 2600,
  parameter int T_RC         = 10,
  parameter int T_RAS        = 7,
  parameter int MAX_POSTPONE = 8,
  parameter int CATCHUP_N    = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic urgent_o,
  output logic own_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  logic      tick, clear, issue, owed;
  seq_op_e   op;
  cmd_pins_t pins;

  sdram_ref_timer #(.T_REFI(T_REFI)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .tick_o (tick)
  );

  sdram_ref_debt #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (tick),
    .dec_i   (issue),
    .owed_o  (owed),
    .urgent_o(urgent_o)
  );

  sdram_ref_fsm #(
    .T_RC     (T_RC),
    .T_RAS    (T_RAS),
    .CATCHUP_N(CATCHUP_N)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .owed_i  (owed),
    .pd_req_i(pd_req_i),
    .gnt_i   (gnt_i),
    .req_o   (req_o),
    .own_o   (own_o),
    .cke_o   (cke_o),
    .issue_o (issue),
    .clear_o (clear),
    .op_o    (op)
  );

  // self-refresh entry shares the refresh encoding; CKE tells them apart
  assign pins    = (op == OP_NOP) ? PINS_NOP : PINS_REF;
  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_o |-> cke_o && (pins == PINS_NOP));

  a_r3_ref_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o && (pins == PINS_REF) |=> (pins == PINS_NOP));

  a_r7_entry_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (pins == PINS_REF) && own_o);

  a_r9_wake_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (pins == PINS_NOP) ##1 (pins == PINS_NOP));

endmodule

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_refresh_seq_tb;
  localparam int T_REFI = 40;
  localparam int T_RC   = 4;
  localparam int T_RAS  = 6;
  localparam int MAXP   = 3;
  localparam int CU_N   = 5;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_req = 1'b0;
  logic gnt = 1'b0;
  logic req_o, urgent_o, own_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [3:0] pins;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .T_REFI(T_REFI), .T_RC(T_RC), .T_RAS(T_RAS),
    .MAX_POSTPONE(MAXP), .CATCHUP_N(CU_N)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pd_req_i(pd_req), .gnt_i(gnt),
    .req_o(req_o), .urgent_o(urgent_o), .own_o(own_o), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
  );

  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  int n_chk = 0;
  int n_fail = 0;
  int quiet_bad = 0;
  bit done = 1'b0;

  int ref_at [32];
  int nref, sre_at, rise_at, low_cyc, end_at, odd_pins;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // R2: pins stay quiet whenever the block is not the bus owner
  always @(negedge clk)
    if (rst_ni && !own_o && (pins != P_NOP || !cke_o)) quiet_bad++;

  task automatic do_reset();
    rst_ni = 1'b0; pd_req = 1'b0; gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset own", int'(own_o), 0);
    chk("R2 reset cke", int'(cke_o), 1);
    chk("R2 reset pins", int'(pins), int'(P_NOP));
    chk("R5 reset req", int'(req_o), 0);
    chk("R4 reset urgent", int'(urgent_o), 0);
    rst_ni = 1'b1;
  endtask

  // records falling-edge indices, k=0 is the edge where the grant was driven
  task automatic watch(input int drop_k, input int raise_k, input bit drop_on_rise);
    int k = 0;
    bit started = 1'b0;
    logic prev = 1'b1;
    nref = 0; sre_at = -1; rise_at = -1; low_cyc = 0; odd_pins = 0;
    while (k < 300) begin
      @(negedge clk);
      k++;
      if (own_o) started = 1'b1;
      if (started && !own_o) break;
      if (own_o && pins == P_REF && cke_o) begin
        if (nref < 32) ref_at[nref] = k;
        nref++;
      end
      if (pins == P_REF && !cke_o) sre_at = k;
      if (pins != P_REF && pins != P_NOP) odd_pins++;
      if (!cke_o) low_cyc++;
      if (cke_o && !prev) begin
        rise_at = k;
        if (drop_on_rise) pd_req = 1'b0;
      end
      if (k == drop_k)  pd_req = 1'b0;
      if (k == raise_k) pd_req = 1'b1;
      prev = cke_o;
    end
    end_at = k;
  endtask

  initial begin
    int n;
    int bad;

    // ---- first obligation, accumulation and the cap
    do_reset();
    n = 0;
    while (!req_o && n < 1000) begin @(negedge clk); n++; end
    chk("R1 first request edge", n, T_REFI);
    while (n < 3 * T_REFI - 1) begin @(negedge clk); n++; end
    chk("R1 two owed before third period", int'(urgent_o), 0);
    @(negedge clk); n++;
    chk("R1 R4 third owed reaches limit", int'(urgent_o), 1);
    while (n < 5 * T_REFI + 5) begin @(negedge clk); n++; end
    chk("R4 saturated limit", int'(urgent_o), 1);
    chk("R5 no grant no ownership", int'(own_o), 0);
    gnt = 1'b1;
    watch(-1, -1, 1'b0);
    chk("R4 drain count", nref, MAXP);
    chk("R5 first command after grant", ref_at[0], 1);
    chk("R3 spacing 1", ref_at[1] - ref_at[0], T_RC);
    chk("R3 spacing 2", ref_at[2] - ref_at[1], T_RC);
    chk("R3 release after last", end_at, ref_at[2] + T_RC);
    chk("R3 only refresh or nop", odd_pins, 0);
    chk("R5 request drops when drained", int'(req_o), 0);
    chk("R4 limit flag cleared", int'(urgent_o), 0);
    gnt = 1'b0;

    // ---- owed refresh first, then self-refresh, catch-up and timer restart
    do_reset();
    n = 0;
    while (n < T_REFI + 2) begin @(negedge clk); n++; end
    pd_req = 1'b1; gnt = 1'b1;
    watch(35, -1, 1'b0);
    chk("R6 owed refresh first", ref_at[0], 1);
    chk("R6 R7 entry one gap later", sre_at, 1 + T_RC);
    chk("R7 low while requested", low_cyc, 35 - (1 + T_RC) + 1);
    chk("R8 exit when allowed", rise_at, 36);
    chk("R9 wake nops", ref_at[1] - rise_at, T_RC);
    chk("R10 total refreshes", nref, 1 + CU_N);
    bad = 0;
    for (int i = 1; i < CU_N; i++) if (ref_at[i + 1] - ref_at[i] != T_RC) bad++;
    chk("R10 catch-up spacing", bad, 0);
    chk("R10 release after catch-up", end_at, ref_at[CU_N] + T_RC);
    gnt = 1'b0;
    n = 0;
    while (!req_o && n < 1000) begin @(negedge clk); n++; end
    chk("R10 timer restarted", n, T_REFI);

    // ---- early withdrawal, queued exit, minimum low time
    do_reset();
    repeat (2) @(negedge clk);
    pd_req = 1'b1;
    @(negedge clk);
    chk("R5 request from power-down", int'(req_o), 1);
    repeat (2) @(negedge clk);
    chk("R5 waits for grant", int'(own_o), 0);
    gnt = 1'b1;
    watch(1, 2, 1'b1);
    chk("R7 entry first command", sre_at, 1);
    chk("R8 minimum low time", low_cyc, T_RAS);
    chk("R8 queued exit despite re-request", rise_at, 1 + T_RAS);
    chk("R9 wake nops", ref_at[0] - rise_at, T_RC);
    chk("R10 catch-up count", nref, CU_N);
    chk("R10 idle after catch-up", int'(req_o), 0);
    gnt = 1'b0;
    repeat (3) @(negedge clk);

    chk("R2 quiet when not owner", quiet_bad, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

endmodule